// File: doc/BRIEF.md
# Load/Store Memory-Access and Writeback Slice

This block is the memory-access and register-writeback slice of a single-cycle 32-bit processor core. It receives the current instruction word, the two register-file read values, the ALU result with its sign flag, and the read data returned by an asynchronous data memory. From these it forms the effective address, raises the word or byte write strobe, and tells the memory whether a read is in progress. It also realigns a loaded byte, and selects the value that goes back to the register file.

Address formation is always base plus a sign-extended 16-bit offset. Byte loads take one of the four byte lanes of the read word, selected by the two lowest address bits, and extend it with zeros or with its sign bit. Word accesses to an address that is not a multiple of four are faulted: no memory write and no register write take place. The writeback value, destination number and enable are captured in a register at the clock edge that closes the instruction's cycle.

Top module: `lsu_mem_wb`

## Requirements
- R1: The instruction is split as opcode [31:26], rs [25:21], rt [20:16], offset [15:0]. `mem_addr` equals `rs_val` plus the offset sign-extended to 32 bits, modulo 2^32, for every instruction. `rf_rs_sel` and `rf_rt_sel` carry the rs and rt fields.
- R2: Opcode 0x2B (word store) asserts `mem_word_we` and opcode 0x28 (byte store) asserts `mem_byte_we`. Every other opcode asserts neither. `mem_wdata` always equals `rt_val`.
- R3: `mem_read` is high exactly for the load opcodes 0x23 (word), 0x24 (byte, unsigned) and 0x20 (byte, signed).
- R4: An unsigned byte load returns lane k = `mem_rdata[8k+7:8k]`, where k = `mem_addr[1:0]`, with the upper 24 bits zero.
- R5: A signed byte load returns the same lane with bit 7 copied into the upper 24 bits.
- R6: A word load writes back `mem_rdata`. Opcode 0x0F writes back offset<<16. For opcode 0x00 the destination is bits [15:11]: function code 0x2A in bits [5:0] writes back {31 zeros, `alu_neg`}, and any other function code writes back `alu_res`. I-type writebacks target rt.
- R7: The writeback value, destination and enable appear on `wb_*` one clock edge after the instruction is presented. Stores and all opcodes other than 0x00, 0x0F and the loads leave `wb_en` low.
- R8: A writeback whose destination is register 0 is discarded (`wb_en` stays low).
- R9: A word load or word store whose address has nonzero bits [1:0] raises `misalign` in the same cycle, keeps `mem_word_we` low and leaves `wb_en` low in the next cycle. Byte accesses never fault.
- R10: While `rst_n` is low, `wb_en`, `wb_num` and `wb_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Base register value |
| rt_val | input | 32 | Second register value (store data) |
| alu_res | input | 32 | ALU result for register-format operations |
| alu_neg | input | 1 | ALU negative flag |
| mem_rdata | input | 32 | Data memory read word |
| rf_rs_sel | output | 5 | Register-file read select for the base |
| rf_rt_sel | output | 5 | Register-file read select for the second operand |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Memory write data |
| mem_word_we | output | 1 | Word write strobe |
| mem_byte_we | output | 1 | Byte write strobe |
| mem_read | output | 1 | Load in progress |
| misalign | output | 1 | Misaligned word access fault |
| wb_en | output | 1 | Registered writeback enable |
| wb_num | output | 5 | Registered destination register |
| wb_data | output | 32 | Registered writeback value |

## Verification
The bench builds the block with its default 32-bit data width and 16-bit offset. At that width all four byte lanes, both extension modes, and offsets at the positive and negative extremes can be reached. Address wrap-around past 2^32 is also in range. The vectors cover every lane position and a faulting case for each of the two word operations. They also cover set-less-than with both flag values, a write aimed at register 0, and an unrecognised opcode. A reset asserted after a live writeback shows that the writeback register is cleared.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LDW   = 6'h23;
    localparam logic [5:0] OPC_STW   = 6'h2B;
    localparam logic [5:0] OPC_LDBU  = 6'h24;
    localparam logic [5:0] OPC_LDBS  = 6'h20;
    localparam logic [5:0] OPC_STB   = 6'h28;
    localparam logic [5:0] OPC_UPPER = 6'h0F;
    localparam logic [5:0] FN_LESS   = 6'h2A;

    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_ALU,
        SRC_LESS,
        SRC_UPPER
    } wb_src_e;

    typedef struct packed {
        logic    is_load;
        logic    is_store;
        logic    word_sz;
        logic    sign_ext;
        logic    wb_req;
        logic    dest_rd;
        wb_src_e src;
    } ctrl_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.src = SRC_ALU;
        unique case (opcode)
            OPC_LDW: begin
                ctrl.is_load = 1'b1;
                ctrl.word_sz = 1'b1;
                ctrl.wb_req  = 1'b1;
                ctrl.src     = SRC_MEM;
            end
            OPC_LDBU: begin
                ctrl.is_load = 1'b1;
                ctrl.wb_req  = 1'b1;
                ctrl.src     = SRC_MEM;
            end
            OPC_LDBS: begin
                ctrl.is_load  = 1'b1;
                ctrl.sign_ext = 1'b1;
                ctrl.wb_req   = 1'b1;
                ctrl.src      = SRC_MEM;
            end
            OPC_STW: begin
                ctrl.is_store = 1'b1;
                ctrl.word_sz  = 1'b1;
            end
            OPC_STB: begin
                ctrl.is_store = 1'b1;
            end
            OPC_UPPER: begin
                ctrl.wb_req = 1'b1;
                ctrl.src    = SRC_UPPER;
            end
            OPC_REG: begin
                ctrl.wb_req  = 1'b1;
                ctrl.dest_rd = 1'b1;
                ctrl.src     = (funct == FN_LESS) ? SRC_LESS : SRC_ALU;
            end
            default: ctrl = '{default: '0, src: SRC_ALU};
        endcase
    end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  base,
    input  logic [OFF_W-1:0] offset,
    input  logic             word_access,
    output logic [XLEN-1:0]  addr,
    output logic             misalign
);

    localparam int LANES = XLEN / 8;
    localparam int SEL_W = $clog2(LANES);

    logic [XLEN-1:0] off_ext;

    always_comb begin
        off_ext  = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
        addr     = base + off_ext;
        misalign = word_access && (addr[SEL_W-1:0] != '0);
    end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]              rdata,
    input  logic [$clog2(XLEN/8)-1:0]    lane_sel,
    input  logic                         sign_ext,
    output logic [XLEN-1:0]              byte_val
);

    localparam int LANES = XLEN / 8;

    logic [7:0] lane [LANES];
    logic [7:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = rdata[8*g +: 8];
    end

    always_comb begin
        picked   = lane[lane_sel];
        byte_val = {{(XLEN-8){sign_ext & picked[7]}}, picked};
    end

endmodule

// File: rtl/lsu_mem_wb.sv
module lsu_mem_wb
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [XLEN-1:0]  alu_res,
    input  logic             alu_neg,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [REG_W-1:0] rf_rs_sel,
    output logic [REG_W-1:0] rf_rt_sel,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             mem_word_we,
    output logic             mem_byte_we,
    output logic             mem_read,
    output logic             misalign,
    output logic             wb_en,
    output logic [REG_W-1:0] wb_num,
    output logic [XLEN-1:0]  wb_data
);

    localparam int SEL_W = $clog2(XLEN / 8);

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] num;
        logic [XLEN-1:0]  data;
    } wb_t;

    ctrl_t            ctrl;
    logic [XLEN-1:0]  byte_val;
    logic [REG_W-1:0] dest;
    wb_t              wb_d, wb_q;

    lsu_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    lsu_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
        .base        (rs_val),
        .offset      (instr[OFF_W-1:0]),
        .word_access (ctrl.word_sz & (ctrl.is_load | ctrl.is_store)),
        .addr        (mem_addr),
        .misalign    (misalign)
    );

    lsu_load_align #(.XLEN(XLEN)) u_align (
        .rdata    (mem_rdata),
        .lane_sel (mem_addr[SEL_W-1:0]),
        .sign_ext (ctrl.sign_ext),
        .byte_val (byte_val)
    );

    always_comb begin
        rf_rs_sel   = instr[25:21];
        rf_rt_sel   = instr[20:16];
        mem_wdata   = rt_val;
        mem_read    = ctrl.is_load;
        mem_word_we = ctrl.is_store & ctrl.word_sz & ~misalign;
        mem_byte_we = ctrl.is_store & ~ctrl.word_sz;
        dest        = ctrl.dest_rd ? instr[15:11] : instr[20:16];

        wb_d.num = dest;
        wb_d.en  = ctrl.wb_req & ~misalign & (dest != '0);
        unique case (ctrl.src)
            SRC_MEM:   wb_d.data = ctrl.word_sz ? mem_rdata : byte_val;
            SRC_LESS:  wb_d.data = {{(XLEN-1){1'b0}}, alu_neg};
            SRC_UPPER: wb_d.data = {instr[15:0], {(XLEN-16){1'b0}}};
            default:   wb_d.data = alu_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_en   = wb_q.en;
    assign wb_num  = wb_q.num;
    assign wb_data = wb_q.data;

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_word_we, mem_byte_we}));

    a_r3_read_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> !(mem_word_we || mem_byte_we));

    a_r9_fault_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> !mem_word_we);

    a_r9_word_write_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_word_we |-> (mem_addr[SEL_W-1:0] == '0));

    a_r9_fault_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !wb_en);

    a_r8_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_num != '0));

    a_r7_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_word_we || mem_byte_we) |=> !wb_en);

endmodule

// File: tb/lsu_mem_wb_tb.sv
module lsu_mem_wb_tb;

    localparam int WATCHDOG = 5000;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rt;
        logic [15:0] imm;
        logic [31:0] rs_v;
        logic [31:0] rt_v;
        logic [31:0] alu;
        logic        neg;
        logic [31:0] rdata;
        logic [31:0] e_addr;
        logic        e_wwe;
        logic        e_bwe;
        logic        e_rd;
        logic        e_mis;
        logic        e_wen;
        logic [4:0]  e_num;
        logic [31:0] e_data;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{6'h23, 5'd5,  16'h0004, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'h33221100, 32'h10010004, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd5,  32'h33221100},
        '{6'h2B, 5'd12, 16'h0000, 32'h10010000, 32'hAABBCCDD, 32'h0,        1'b0, 32'h0,        32'h10010000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd12, 32'h0},
        '{6'h24, 5'd12, 16'h0002, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'hF4F3F2F1, 32'h10010002, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd12, 32'h000000F3},
        '{6'h20, 5'd12, 16'h0002, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'hF4F3F2F1, 32'h10010002, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd12, 32'hFFFFFFF3},
        '{6'h20, 5'd3,  16'h0001, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'h00007F00, 32'h10010001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd3,  32'h0000007F},
        '{6'h28, 5'd4,  16'h0003, 32'h10010000, 32'h000000EE, 32'h0,        1'b0, 32'h0,        32'h10010003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd4,  32'h0},
        '{6'h23, 5'd6,  16'hFFFC, 32'h10010008, 32'h0,        32'h0,        1'b0, 32'h12345678, 32'h10010004, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd6,  32'h12345678},
        '{6'h23, 5'd6,  16'h0002, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'h12345678, 32'h10010002, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd6,  32'h0},
        '{6'h2B, 5'd6,  16'h0001, 32'h10010000, 32'h01020304, 32'h0,        1'b0, 32'h0,        32'h10010001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd6,  32'h0},
        '{6'h0F, 5'd7,  16'hABCD, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'h0,        32'h1000ABCD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd7,  32'hABCD0000},
        '{6'h00, 5'd0,  16'h482A, 32'h10010000, 32'h0,        32'h0,        1'b1, 32'h0,        32'h1001482A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd9,  32'h00000001},
        '{6'h00, 5'd0,  16'h482A, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'h0,        32'h1001482A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd9,  32'h00000000},
        '{6'h00, 5'd0,  16'h5020, 32'h10010000, 32'h0,        32'hDEADBEEF, 1'b1, 32'h0,        32'h10015020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd10, 32'hDEADBEEF},
        '{6'h23, 5'd0,  16'h0000, 32'h10010000, 32'h0,        32'h0,        1'b0, 32'h5555AAAA, 32'h10010000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  32'h0},
        '{6'h20, 5'd8,  16'h7FFF, 32'h00000000, 32'h0,        32'h0,        1'b0, 32'h80000000, 32'h00007FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd8,  32'hFFFFFF80},
        '{6'h24, 5'd8,  16'h8000, 32'h00010000, 32'h0,        32'h0,        1'b0, 32'h000000A5, 32'h00008000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd8,  32'h000000A5},
        '{6'h08, 5'd11, 16'h0004, 32'h10010000, 32'h0,        32'h00000001, 1'b0, 32'h0,        32'h10010004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd11, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] alu_res = '0;
    logic        alu_neg = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rf_rs_sel, rf_rt_sel;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_word_we, mem_byte_we, mem_read, misalign;
    logic        wb_en;
    logic [4:0]  wb_num;
    logic [31:0] wb_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lsu_mem_wb u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr       (instr),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .alu_res     (alu_res),
        .alu_neg     (alu_neg),
        .mem_rdata   (mem_rdata),
        .rf_rs_sel   (rf_rs_sel),
        .rf_rt_sel   (rf_rt_sel),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_word_we (mem_word_we),
        .mem_byte_we (mem_byte_we),
        .mem_read    (mem_read),
        .misalign    (misalign),
        .wb_en       (wb_en),
        .wb_num      (wb_num),
        .wb_data     (wb_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        instr     = {v.op, 5'd1, v.rt, v.imm};
        rs_val    = v.rs_v;
        rt_val    = v.rt_v;
        alu_res   = v.alu;
        alu_neg   = v.neg;
        mem_rdata = v.rdata;
        #5;
        chk(mem_addr == v.e_addr, $sformatf("R1 addr v%0d", idx), mem_addr, v.e_addr);
        chk(rf_rs_sel == 5'd1 && rf_rt_sel == v.rt, $sformatf("R1 selects v%0d", idx),
            {22'd0, rf_rs_sel, rf_rt_sel}, {22'd0, 5'd1, v.rt});
        chk(mem_word_we == v.e_wwe, $sformatf("R2 word strobe v%0d", idx), 32'(mem_word_we), 32'(v.e_wwe));
        chk(mem_byte_we == v.e_bwe, $sformatf("R2 byte strobe v%0d", idx), 32'(mem_byte_we), 32'(v.e_bwe));
        chk(mem_wdata == v.rt_v, $sformatf("R2 wdata v%0d", idx), mem_wdata, v.rt_v);
        chk(mem_read == v.e_rd, $sformatf("R3 read v%0d", idx), 32'(mem_read), 32'(v.e_rd));
        chk(misalign == v.e_mis, $sformatf("R9 fault v%0d", idx), 32'(misalign), 32'(v.e_mis));
        @(posedge clk);
        #5;
        chk(wb_en == v.e_wen, $sformatf("R7/R8 wb_en v%0d", idx), 32'(wb_en), 32'(v.e_wen));
        if (v.e_wen) begin
            chk(wb_num == v.e_num, $sformatf("R6 dest v%0d", idx), 32'(wb_num), 32'(v.e_num));
            chk(wb_data == v.e_data, $sformatf("R4/R5/R6 data v%0d", idx), wb_data, v.e_data);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R10: reset state of the writeback register
        chk(wb_en == 1'b0 && wb_num == '0 && wb_data == '0, "R10 reset state",
            {wb_en, 26'd0, wb_num}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R10: reset clears a live writeback
        run_vec(VEC[0], 100);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        chk(wb_en == 1'b0 && wb_data == '0 && wb_num == '0, "R10 reset clears wb",
            wb_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: a byte store on an odd address is not a fault
        run_vec(VEC[5], 101);

        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule